// File: doc/BRIEF.md
# Full-Speed USB Receive Front End

This block turns the sampled line state of a full-speed USB port into a stream of decoded data bits. The line inputs are a differential data level and the two single-ended levels of D+ and D-. A 48 MHz clock samples them, four samples to each 12 Mb/s bit. A level must hold for two samples before it counts, so short spikes are dropped. Every accepted level change restarts the bit timing, and each bit is read at a fixed slot after that edge.

The bit reader undoes the NRZI coding and hunts for the sync pattern. After sync it passes payload bits out with a one-cycle valid strobe, and it removes the zero inserted after each run of six ones. A seventh one where a stuffed zero belongs is flagged as an error and discards the rest of the packet. A single-ended zero of at least one bit time, followed by the idle level, ends the packet and sends the reader back to sync hunting. CRC, PID and endpoint handling are left to the logic downstream.

Top module: `usb_fs_rx_front`

## Requirements
- R1: Line state is SE0 whenever D+ and D- are both low, whatever the differential input shows. Otherwise it is J when the differential input is 1 and K when it is 0. A differential change during SE0 has no effect on any output.
- R2: A line state seen in only one 48 MHz sample is ignored. It moves neither the bit timing nor any output.
- R3: Each accepted line change restarts bit timing, and the bit is read at slot 2 (the edge sample is slot 0). The decoded result is driven during the cycle after the fourth clock edge that follows the first clock edge on which the new bit is seen.
- R4: NRZI decode: a bit with the same J/K level as the previous bit decodes as 1, and a bit with a change decodes as 0.
- R5: sop pulses for one cycle when the line bits KJKJKJKK have been received after idle J. These bits decode to 0000_0001. bit_valid stays low for the sync bits and for everything before them.
- R6: After six consecutive decoded ones, the next bit is dropped when it is 0. The final 1 of the sync counts toward the six.
- R7: A 1 where a stuffed 0 is due raises stuff_err for one cycle. No further bit_valid follows until the end of the packet.
- R8: A filtered SE0 lasting at least four samples, followed by J, pulses eop for one cycle. eop appears during the cycle after the second clock edge following the first J sample, and the receiver then hunts for sync again.
- R9: While reset is asserted all outputs are low. After reset the receiver hunts for sync and produces no data from a line without one.
- R10: bit_valid, sop, eop and stuff_err are single-cycle pulses, never two at once. There is at most one bit_valid per bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_diff | input | 1 | Differential receiver output (1 = D+ above D-) |
| rx_dp | input | 1 | Single-ended D+ level |
| rx_dm | input | 1 | Single-ended D- level |
| bit_out | output | 1 | Decoded data bit, meaningful when bit_valid is high |
| bit_valid | output | 1 | One-cycle strobe for each payload bit |
| sop | output | 1 | One-cycle pulse after the sync pattern |
| eop | output | 1 | One-cycle pulse at end of packet |
| stuff_err | output | 1 | One-cycle pulse on a bit-stuffing violation |

## Verification
A bit is first seen on the clock edge at the start of its period. Its decoded result appears one cycle after the fourth edge that follows, which is the first sample of the next bit period. eop instead appears two edges after the first J sample, inside the J bit's own period. The bench therefore holds each line bit for four clocks and collects every output over those four samples. It compares the valid, data and sop results of a bit against the following bit's window, and eop against the window of the J that ends the SE0. Glitches are placed only on bits that carry no transition, so the expected timing stays fixed.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'd0,
    LS_J   = 2'd1,
    LS_K   = 2'd2
  } line_t;

  typedef enum logic [1:0] {
    FR_HUNT = 2'd0,
    FR_DATA = 2'd1,
    FR_BAD  = 2'd2
  } frame_t;

  // SE0 (both single-ended lines low) overrides the slower differential input.
  function automatic line_t classify(input logic diff, input logic dp, input logic dm);
    if (!dp && !dm) return LS_SE0;
    return diff ? LS_J : LS_K;
  endfunction

endpackage

// File: rtl/usbrx_deglitch.sv
module usbrx_deglitch
  import usbrx_pkg::*;
#(
  parameter int GLITCH_MIN = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_diff,
  input  logic  in_dp,
  input  logic  in_dm,
  output line_t line_o
);

  localparam int HIST = GLITCH_MIN - 1;
  localparam int HW   = 2 * HIST;

  line_t          raw;
  logic [HW-1:0]  hist_q, hist_d;
  logic           agree;
  line_t          line_q, line_d;

  assign raw = classify(in_diff, in_dp, in_dm);

  if (HIST == 1) begin : g_one
    assign hist_d = raw;
  end else begin : g_many
    assign hist_d = {hist_q[HW-3:0], raw};
  end

  // Accept a new level only when it matches every stored sample.
  always_comb begin
    agree = 1'b1;
    for (int i = 0; i < HIST; i++) begin
      if (hist_q[2*i +: 2] != raw) agree = 1'b0;
    end
    line_d = agree ? raw : line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= {HIST{2'd1}};
      line_q <= LS_J;
    end else begin
      hist_q <= hist_d;
      line_q <= line_d;
    end
  end

  assign line_o = line_q;

endmodule

// File: rtl/usbrx_dpll.sv
module usbrx_dpll
  import usbrx_pkg::*;
#(
  parameter int SPB  = 4,
  parameter int SLOT = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  line_t line_i,
  output logic  stb_o,
  output line_t samp_o
);

  localparam int CW = (SPB > 1) ? $clog2(SPB) : 1;

  line_t         prev_q;
  logic [CW-1:0] cnt_q, cnt_d, slot;
  logic          edge_w;

  always_comb begin
    edge_w = (line_i != prev_q);
    slot   = edge_w ? '0 : cnt_q;
    cnt_d  = (slot == CW'(SPB - 1)) ? '0 : slot + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= LS_J;
      cnt_q  <= '0;
    end else begin
      prev_q <= line_i;
      cnt_q  <= cnt_d;
    end
  end

  assign stb_o  = (slot == CW'(SLOT));
  assign samp_o = line_i;

endmodule

// File: rtl/usbrx_framer.sv
module usbrx_framer
  import usbrx_pkg::*;
#(
  parameter int SYNC_LEN  = 8,
  parameter int STUFF_RUN = 6,
  parameter int EOP_MIN   = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stb_i,
  input  line_t samp_i,
  input  line_t line_i,
  output logic  bit_o,
  output logic  vld_o,
  output logic  sop_o,
  output logic  eop_o,
  output logic  err_o
);

  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam int EW = $clog2(EOP_MIN + 1);
  localparam logic [SYNC_LEN-1:0] SYNC_PAT = {{(SYNC_LEN-1){1'b0}}, 1'b1};

  frame_t              st_q, st_d;
  line_t               lvl_q, lvl_d;
  logic [SYNC_LEN-1:0] sh_q, sh_d;
  logic [OW-1:0]       ones_q, ones_d;
  logic [EW-1:0]       se0_q, se0_d;
  logic                bit_d, vld_d, sop_d, eop_d, err_d;
  logic                dbit, jk, eop_hit;

  always_comb begin
    dbit    = (samp_i == lvl_q);
    jk      = (samp_i != LS_SE0);
    eop_hit = (st_q != FR_HUNT) && (line_i == LS_J) && (se0_q == EW'(EOP_MIN));

    st_d   = st_q;
    lvl_d  = lvl_q;
    sh_d   = sh_q;
    ones_d = ones_q;
    bit_d  = 1'b0;
    vld_d  = 1'b0;
    sop_d  = 1'b0;
    eop_d  = 1'b0;
    err_d  = 1'b0;

    if (line_i != LS_SE0)            se0_d = '0;
    else if (se0_q != EW'(EOP_MIN))  se0_d = se0_q + 1'b1;
    else                             se0_d = se0_q;

    if (stb_i && jk) lvl_d = samp_i;

    if (eop_hit) begin
      eop_d = 1'b1;
      st_d  = FR_HUNT;
      sh_d  = '1;
      lvl_d = LS_J;
    end else if (stb_i) begin
      unique case (st_q)
        FR_HUNT: begin
          if (!jk) begin
            sh_d = '1;
          end else begin
            sh_d = {sh_q[SYNC_LEN-2:0], dbit};
            if (sh_d == SYNC_PAT) begin
              sop_d  = 1'b1;
              st_d   = FR_DATA;
              ones_d = OW'(1);
            end
          end
        end
        FR_DATA: begin
          if (jk) begin
            if (ones_q == OW'(STUFF_RUN)) begin
              if (dbit) begin
                err_d = 1'b1;
                st_d  = FR_BAD;
              end else begin
                ones_d = '0;
              end
            end else begin
              vld_d  = 1'b1;
              bit_d  = dbit;
              ones_d = dbit ? ones_q + 1'b1 : '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_HUNT;
      lvl_q  <= LS_J;
      sh_q   <= '1;
      ones_q <= '0;
      se0_q  <= '0;
      bit_o  <= 1'b0;
      vld_o  <= 1'b0;
      sop_o  <= 1'b0;
      eop_o  <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      lvl_q  <= lvl_d;
      sh_q   <= sh_d;
      ones_q <= ones_d;
      se0_q  <= se0_d;
      bit_o  <= bit_d;
      vld_o  <= vld_d;
      sop_o  <= sop_d;
      eop_o  <= eop_d;
      err_o  <= err_d;
    end
  end

endmodule

// File: rtl/usb_fs_rx_front.sv
module usb_fs_rx_front
  import usbrx_pkg::*;
#(
  parameter int OVERSAMPLE  = 4,
  parameter int SAMPLE_SLOT = 2,
  parameter int GLITCH_MIN  = 2,
  parameter int SYNC_LEN    = 8,
  parameter int STUFF_RUN   = 6,
  parameter int EOP_MIN     = OVERSAMPLE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_diff,
  input  logic rx_dp,
  input  logic rx_dm,
  output logic bit_out,
  output logic bit_valid,
  output logic sop,
  output logic eop,
  output logic stuff_err
);

  logic [1:0] rst_pipe;
  logic       rst_core_n;
  line_t      line_filt;
  line_t      samp_line;
  logic       samp_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  usbrx_deglitch #(.GLITCH_MIN(GLITCH_MIN)) u_deglitch (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .in_diff (rx_diff),
    .in_dp   (rx_dp),
    .in_dm   (rx_dm),
    .line_o  (line_filt)
  );

  usbrx_dpll #(.SPB(OVERSAMPLE), .SLOT(SAMPLE_SLOT)) u_dpll (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .line_i (line_filt),
    .stb_o  (samp_stb),
    .samp_o (samp_line)
  );

  usbrx_framer #(.SYNC_LEN(SYNC_LEN), .STUFF_RUN(STUFF_RUN), .EOP_MIN(EOP_MIN)) u_framer (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .stb_i  (samp_stb),
    .samp_i (samp_line),
    .line_i (line_filt),
    .bit_o  (bit_out),
    .vld_o  (bit_valid),
    .sop_o  (sop),
    .eop_o  (eop),
    .err_o  (stuff_err)
  );

endmodule

// File: rtl/usbrx_checker.sv
module usbrx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_diff,
  input logic       rx_dp,
  input logic       rx_dm,
  input logic       bit_valid,
  input logic       sop,
  input logic       eop,
  input logic       stuff_err,
  input logic       samp_stb,
  input logic [1:0] line_filt
);

  logic [1:0] age_q;
  logic       ready;
  logic [1:0] raw_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign ready = (age_q == 2'd3);

  // Checker's own view of the pin levels: 0 = SE0, 1 = J, 2 = K.
  always_comb begin
    if (!rx_dp && !rx_dm) raw_c = 2'd0;
    else if (rx_diff)     raw_c = 2'd1;
    else                  raw_c = 2'd2;
  end

  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_valid, sop, eop, stuff_err}));

  p_valid_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  p_valid_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && bit_valid) |-> $past(samp_stb));

  p_glitch_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !$stable(line_filt)) |-> (line_filt == $past(raw_c) && $past(raw_c) == $past(raw_c, 2)));

  p_eop_on_j_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && eop) |-> ($past(raw_c, 2) == 2'd1 && $past(raw_c, 3) == 2'd1));

  p_sop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sop |=> !bit_valid);

endmodule

bind usb_fs_rx_front usbrx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .rx_diff   (rx_diff),
  .rx_dp     (rx_dp),
  .rx_dm     (rx_dm),
  .bit_valid (bit_valid),
  .sop       (sop),
  .eop       (eop),
  .stuff_err (stuff_err),
  .samp_stb  (samp_stb),
  .line_filt (line_filt)
);

// File: tb/tb_usb_fs_rx_front.sv
module tb_usb_fs_rx_front;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_diff, rx_dp, rx_dm;
  logic bit_out, bit_valid, sop, eop, stuff_err;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  usb_fs_rx_front dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_diff   (rx_diff),
    .rx_dp     (rx_dp),
    .rx_dm     (rx_dm),
    .bit_out   (bit_out),
    .bit_valid (bit_valid),
    .sop       (sop),
    .eop       (eop),
    .stuff_err (stuff_err)
  );

  // Row: [8:7] symbol (0 SE0, 1 J, 2 K), [6:5] disturbance
  // (0 none, 1 one-sample opposite level, 2 one-sample SE0, 3 diff toggling),
  // [4:0] expected in this bit's window: valid, bit, sop, eop, stuff_err.
  localparam int NV = 47;
  localparam logic [8:0] VEC [NV] = '{
    {2'd1,2'd0,5'b00000}, {2'd1,2'd1,5'b00000}, {2'd1,2'd0,5'b00000},
    {2'd2,2'd0,5'b00000}, {2'd1,2'd0,5'b00000}, {2'd2,2'd0,5'b00000},
    {2'd1,2'd0,5'b00000}, {2'd2,2'd0,5'b00000}, {2'd1,2'd0,5'b00000},
    {2'd2,2'd0,5'b00000}, {2'd2,2'd0,5'b00000}, {2'd2,2'd0,5'b00100},
    {2'd2,2'd0,5'b11000}, {2'd2,2'd2,5'b11000}, {2'd2,2'd1,5'b11000},
    {2'd2,2'd0,5'b11000}, {2'd1,2'd0,5'b11000}, {2'd2,2'd0,5'b00000},
    {2'd2,2'd0,5'b10000}, {2'd0,2'd3,5'b11000}, {2'd0,2'd3,5'b00000},
    {2'd1,2'd0,5'b00010}, {2'd1,2'd0,5'b00000}, {2'd2,2'd0,5'b00000},
    {2'd2,2'd0,5'b00000}, {2'd1,2'd0,5'b00000}, {2'd1,2'd0,5'b00000},
    {2'd1,2'd0,5'b00000}, {2'd1,2'd0,5'b00000}, {2'd2,2'd0,5'b00000},
    {2'd1,2'd0,5'b00000}, {2'd2,2'd0,5'b00000}, {2'd1,2'd0,5'b00000},
    {2'd2,2'd0,5'b00000}, {2'd1,2'd0,5'b00000}, {2'd2,2'd0,5'b00000},
    {2'd2,2'd0,5'b00000}, {2'd2,2'd0,5'b00100}, {2'd2,2'd0,5'b11000},
    {2'd2,2'd0,5'b11000}, {2'd2,2'd0,5'b11000}, {2'd2,2'd0,5'b11000},
    {2'd2,2'd0,5'b11000}, {2'd0,2'd0,5'b00001}, {2'd0,2'd0,5'b00000},
    {2'd1,2'd0,5'b00010}, {2'd1,2'd0,5'b00000}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int sym, input int dflip);
    case (sym)
      0:       begin rx_dp = 1'b0; rx_dm = 1'b0; rx_diff = dflip[0]; end
      1:       begin rx_dp = 1'b1; rx_dm = 1'b0; rx_diff = 1'b1;     end
      default: begin rx_dp = 1'b0; rx_dm = 1'b1; rx_diff = 1'b0;     end
    endcase
  endtask

  // Called at a falling edge; holds one bit for four clocks and gathers outputs.
  task automatic run_sym(input int sym, input int g,
                         output int nv, output int lb, output int so,
                         output int eo, output int er);
    nv = 0; lb = 0; so = 0; eo = 0; er = 0;
    for (int c = 0; c < 4; c++) begin
      int s = sym;
      if (c == 1 && g == 1) s = (sym == 1) ? 2 : 1;
      if (c == 1 && g == 2) s = 0;
      drive(s, (g == 3) ? (c % 2) : 0);
      @(posedge clk);
      @(negedge clk);
      if (bit_valid) begin nv++; lb = int'(bit_out); end
      so += int'(sop);
      eo += int'(eop);
      er += int'(stuff_err);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int nv, lb, so, eo, er, acc;
    string tag;
    rst_n = 1'b0;
    drive(1, 0);
    repeat (3) @(negedge clk);
    // R9: outputs low while reset is held
    check("R9 reset bit_valid", int'(bit_valid), 0);
    check("R9 reset sop",       int'(sop),       0);
    check("R9 reset eop",       int'(eop),       0);
    check("R9 reset stuff_err", int'(stuff_err), 0);
    check("R9 reset bit_out",   int'(bit_out),   0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [8:0] v = VEC[i];
      run_sym(int'(v[8:7]), int'(v[6:5]), nv, lb, so, eo, er);
      if (v[6:5] == 2'd3)      tag = "R1";
      else if (v[6:5] != 2'd0) tag = "R2";
      else                     tag = "R4";
      check($sformatf("%s R10 valid count row %0d", tag, i), nv, int'(v[4]));
      if (v[4]) check($sformatf("%s R3 R6 data bit row %0d", tag, i), lb, int'(v[3]));
      check($sformatf("R5 sop row %0d", i), so, int'(v[2]));
      check($sformatf("R8 eop row %0d", i), eo, int'(v[1]));
      check($sformatf("R7 stuff_err row %0d", i), er, int'(v[0]));
    end

    // Directed: reset in the middle of a packet, then a line without sync.
    run_sym(1, 0, nv, lb, so, eo, er);
    run_sym(1, 0, nv, lb, so, eo, er);
    for (int k = 0; k < 8; k++) run_sym((k % 2 == 0 || k == 7) ? 2 : 1, 0, nv, lb, so, eo, er);
    run_sym(2, 0, nv, lb, so, eo, er);
    check("R5 sop before mid-packet reset", so, 1);
    run_sym(2, 0, nv, lb, so, eo, er);
    check("R4 data before mid-packet reset", nv, 1);
    rst_n = 1'b0;
    drive(1, 0);
    @(posedge clk);
    @(negedge clk);
    check("R9 outputs cleared by reset", int'({bit_valid, sop, eop, stuff_err}), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    acc = 0;
    run_sym(1, 0, nv, lb, so, eo, er); acc += nv + so + er;
    run_sym(1, 0, nv, lb, so, eo, er); acc += nv + so + er;
    for (int k = 0; k < 8; k++) begin
      run_sym(((k / 2) % 2 == 0) ? 2 : 1, 0, nv, lb, so, eo, er);
      acc += nv + so + eo + er;
    end
    check("R9 R5 no output without sync after reset", acc, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule